// File: doc/BRIEF.md
# Single-Port Synchronous RAM

This block is a parameterised storage array with one shared address port. In each input clock cycle it carries out at most one operation, either a read or a write. Address, write data, write enable and byte-lane enables are all sampled on the rising edge of the input clock, so no input reaches the array without passing a clock edge. A byte-enable vector restricts a write to chosen lanes of the word. A clock enable freezes the whole block. An address-stall input keeps the previously captured address in force, so a run of accesses can reuse it without driving the address bus again.

A build-time switch chooses how the read data is produced. In the registered form, the word read out is captured at the same input edge as the address. In the flow-through form, the read output follows the captured address combinationally. A second switch places an output register after the read path. That register runs on its own output clock and has an asynchronous clear.

A further parameter sets what the read output shows when the cycle is a write. The options are the word as it stands after the write, the word as it stood before it, or an unspecified value. The unspecified option costs the least logic, and no check is made on that value.

Top module: `sp_sync_ram`

## Requirements
- R1: A write (wrEn high with clkEn high at a rising inClk edge) stores wrData at the effective address at that edge; a later read of that address returns it.
- R2: byteEn bit i governs data bits [8i+7:8i]; during a write only lanes whose bit is 1 change, and the other lanes keep their stored bytes, including when byteEn is all zero.
- R3: With FLOW_THRU=0 and OUT_REG=1, a read (rdEn high, wrEn low, clkEn high) of address A at inClk edge k shows the word at A on rdQ after the first outClk rising edge that follows edge k.
- R4: With RDW=RDW_NEW, the read output of a write cycle is the stored word after the byte-masked write.
- R5: With RDW=RDW_OLD, the read output of a write cycle is the stored word as it was before the write.
- R6: While addrStall is high at an enabled edge, the captured address keeps its old value; reads and writes in that cycle use the held address and the addr input is ignored.
- R7: While clkEn is low, no write happens and the captured address, the read word and the output register all hold their values.
- R8: When clkEn is high and both rdEn and wrEn are low, the read word and rdQ keep their last value.
- R9: outClr high clears rdQ to zero at once, without waiting for a clock edge, and leaves the stored words untouched.
- R10: With FLOW_THRU=1 and OUT_REG=0, rdQ shows the word at the captured address combinationally after the capturing edge, even in cycles with rdEn low.
- R11: When wrEn and rdEn are both high, the cycle is only a write: the read output follows the write-cycle policy of R4 or R5, and no separate read takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inClk | input | 1 | Input clock: samples inputs, writes the array, updates the read word |
| outClk | input | 1 | Clock of the optional output register |
| outClr | input | 1 | Asynchronous clear of the output register, active high |
| clkEn | input | 1 | Clock enable for both domains; low freezes all state |
| addrStall | input | 1 | High keeps the previously captured address |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| byteEn | input | DATA_W/BYTE_W | Per-lane write mask, bit i for lane i |
| addr | input | $clog2(DEPTH) | Word address |
| wrData | input | DATA_W | Write data |
| rdQ | output | DATA_W | Read data |

## Verification
Three copies of the block take the same stimulus: one reports the new word on a write cycle, one reports the old word, and one uses flow-through read with no output register. The stimulus mixes full-word writes, partial-lane writes, an empty mask, plain reads, idle cycles and stalled accesses. These separate the old-word and new-word policies on write cycles, the masked lanes from the written ones, and held output from a flow-through output that tracks the address. A stalled write that lands on the held address instead of the driven one shows that the stall is honoured. Directed phases then drop the clock enable while a write is presented, and pulse the clear between clock edges to show that only the output register is cleared.

// File: rtl/sp_ram_pkg.sv
`timescale 1ns/1ps
package sp_ram_pkg;

  typedef enum logic [1:0] {
    RDW_NEW = 2'd0,
    RDW_OLD = 2'd1,
    RDW_ANY = 2'd2
  } rdw_e;

  // strobes from control to datapath
  typedef struct packed {
    logic addrLoad;
    logic wrStb;
    logic rdStb;
    logic outLoad;
  } ram_stb_t;

endpackage

// File: rtl/sp_ram_ctrl.sv
`timescale 1ns/1ps
module sp_ram_ctrl (
  input  logic                  clkEn,
  input  logic                  addrStall,
  input  logic                  wrEn,
  input  logic                  rdEn,
  output sp_ram_pkg::ram_stb_t  stb
);

  always_comb begin
    stb.addrLoad = clkEn & ~addrStall;
    // a write always wins the single port
    stb.wrStb    = clkEn & wrEn;
    stb.rdStb    = clkEn & rdEn & ~wrEn;
    stb.outLoad  = clkEn;
  end

endmodule

// File: rtl/sp_ram_datapath.sv
`timescale 1ns/1ps
module sp_ram_datapath #(
  parameter int                DATA_W    = 32,
  parameter int                BYTE_W    = 8,
  parameter int                DEPTH     = 64,
  parameter sp_ram_pkg::rdw_e  RDW       = sp_ram_pkg::RDW_NEW,
  parameter bit                OUT_REG   = 1'b1,
  parameter bit                FLOW_THRU = 1'b0,
  localparam int               LANES     = DATA_W / BYTE_W,
  localparam int               ADDR_W    = $clog2(DEPTH)
) (
  input  logic                  inClk,
  input  logic                  outClk,
  input  logic                  outClr,
  input  sp_ram_pkg::ram_stb_t  stb,
  input  logic [LANES-1:0]      byteEn,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic [DATA_W-1:0]     wrData,
  output logic [ADDR_W-1:0]     addrQ,
  output logic [DATA_W-1:0]     rdWord,
  output logic [DATA_W-1:0]     rdQ
);

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] oldWord;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] rdwWord;

  assign effAddr = stb.addrLoad ? addrIn : addrReg;
  assign oldWord = memArr[effAddr];
  assign addrQ   = addrReg;

  always_ff @(posedge inClk) begin
    if (stb.addrLoad) addrReg <= addrIn;
    if (stb.wrStb) begin
      for (int l = 0; l < LANES; l++) begin
        if (byteEn[l]) memArr[effAddr][l*BYTE_W +: BYTE_W] <= wrData[l*BYTE_W +: BYTE_W];
      end
    end
  end

  // word as it stands after a masked write
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mergedWord[g*BYTE_W +: BYTE_W] =
      byteEn[g] ? wrData[g*BYTE_W +: BYTE_W] : oldWord[g*BYTE_W +: BYTE_W];
  end

  if (RDW == sp_ram_pkg::RDW_NEW) begin : g_rdw_new
    assign rdwWord = mergedWord;
  end else begin : g_rdw_old
    // old word is also the cheapest choice when the value is unspecified
    assign rdwWord = oldWord;
  end

  if (FLOW_THRU) begin : g_flow
    assign rdWord = memArr[addrReg];
  end else begin : g_regrd
    logic [DATA_W-1:0] rdReg;
    always_ff @(posedge inClk) begin
      if (stb.rdStb)      rdReg <= oldWord;
      else if (stb.wrStb) rdReg <= rdwWord;
    end
    assign rdWord = rdReg;
  end

  if (OUT_REG) begin : g_oreg
    logic [DATA_W-1:0] qReg;
    always_ff @(posedge outClk or posedge outClr) begin
      if (outClr)           qReg <= '0;
      else if (stb.outLoad) qReg <= rdWord;
    end
    assign rdQ = qReg;
  end else begin : g_nooreg
    assign rdQ = rdWord;
  end

endmodule

// File: rtl/sp_sync_ram.sv
`timescale 1ns/1ps
module sp_sync_ram #(
  parameter int                DATA_W    = 32,
  parameter int                BYTE_W    = 8,
  parameter int                DEPTH     = 64,
  parameter sp_ram_pkg::rdw_e  RDW       = sp_ram_pkg::RDW_NEW,
  parameter bit                OUT_REG   = 1'b1,
  parameter bit                FLOW_THRU = 1'b0,
  localparam int               LANES     = DATA_W / BYTE_W,
  localparam int               ADDR_W    = $clog2(DEPTH)
) (
  input  logic              inClk,
  input  logic              outClk,
  input  logic              outClr,
  input  logic              clkEn,
  input  logic              addrStall,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [LANES-1:0]  byteEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdQ
);

  sp_ram_pkg::ram_stb_t stb;
  logic [ADDR_W-1:0]    addrQ;
  logic [DATA_W-1:0]    rdWord;

  sp_ram_ctrl u_ctrl (
    .clkEn     (clkEn),
    .addrStall (addrStall),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .stb       (stb)
  );

  sp_ram_datapath #(
    .DATA_W    (DATA_W),
    .BYTE_W    (BYTE_W),
    .DEPTH     (DEPTH),
    .RDW       (RDW),
    .OUT_REG   (OUT_REG),
    .FLOW_THRU (FLOW_THRU)
  ) u_dp (
    .inClk  (inClk),
    .outClk (outClk),
    .outClr (outClr),
    .stb    (stb),
    .byteEn (byteEn),
    .addrIn (addr),
    .wrData (wrData),
    .addrQ  (addrQ),
    .rdWord (rdWord),
    .rdQ    (rdQ)
  );

endmodule

// File: rtl/sp_ram_chk.sv
`timescale 1ns/1ps
module sp_ram_chk #(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 6,
  parameter int                LANES     = 4,
  parameter sp_ram_pkg::rdw_e  RDW       = sp_ram_pkg::RDW_NEW,
  parameter bit                OUT_REG   = 1'b1,
  parameter bit                FLOW_THRU = 1'b0
) (
  input logic                  inClk,
  input logic                  outClk,
  input logic                  outClr,
  input logic                  clkEn,
  input logic                  addrStall,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [LANES-1:0]      byteEn,
  input logic [DATA_W-1:0]     wrData,
  input logic [DATA_W-1:0]     rdQ,
  input logic [DATA_W-1:0]     rdWord,
  input logic [ADDR_W-1:0]     addrQ,
  input sp_ram_pkg::ram_stb_t  stb
);

  logic primed = 1'b0;
  always_ff @(posedge inClk) primed <= 1'b1;

  // R6
  stall_addr_chk: assert property (@(posedge inClk) disable iff (!primed)
    clkEn && addrStall |=> $stable(addrQ));

  // R7
  clk_en_hold_chk: assert property (@(posedge inClk) disable iff (!primed)
    !clkEn |=> $stable(rdWord) && $stable(addrQ));

  // R11
  one_op_chk: assert property (@(posedge inClk) disable iff (!primed)
    $onehot0({stb.rdStb, stb.wrStb}));

  if (!FLOW_THRU) begin : g_reg_chk
    // R8
    idle_hold_chk: assert property (@(posedge inClk) disable iff (!primed)
      clkEn && !wrEn && !rdEn |=> $stable(rdWord));
    if (RDW == sp_ram_pkg::RDW_NEW) begin : g_new_chk
      // R4
      new_data_chk: assert property (@(posedge inClk) disable iff (!primed)
        clkEn && wrEn && (&byteEn) |=> rdWord == $past(wrData));
    end
  end

  if (OUT_REG) begin : g_clr_chk
    // R9
    out_clear_chk: assert property (@(posedge outClk)
      outClr |-> rdQ == '0);
  end

endmodule

bind sp_sync_ram sp_ram_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .LANES     (LANES),
  .RDW       (RDW),
  .OUT_REG   (OUT_REG),
  .FLOW_THRU (FLOW_THRU)
) u_chk (
  .inClk     (inClk),
  .outClk    (outClk),
  .outClr    (outClr),
  .clkEn     (clkEn),
  .addrStall (addrStall),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .byteEn    (byteEn),
  .wrData    (wrData),
  .rdQ       (rdQ),
  .rdWord    (rdWord),
  .addrQ     (addrQ),
  .stb       (stb)
);

// File: tb/sp_sync_ram_bench.sv
`timescale 1ns/1ps
module sp_sync_ram_bench;

  logic        inClk = 1'b0;
  logic        outClk = 1'b0;
  logic        outClr = 1'b1;
  logic        clkEn = 1'b1;
  logic        addrStall = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  byteEn = 4'h0;
  logic [5:0]  addr = 6'd0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] qNew, qOld, qFt;

  int checks = 0;
  int errors = 0;

  always #2.5 inClk = ~inClk;
  initial begin
    #1.25;
    forever #2.5 outClk = ~outClk;
  end

  sp_sync_ram u_sp_sync_ram (
    .inClk(inClk), .outClk(outClk), .outClr(outClr), .clkEn(clkEn),
    .addrStall(addrStall), .wrEn(wrEn), .rdEn(rdEn), .byteEn(byteEn),
    .addr(addr), .wrData(wrData), .rdQ(qNew));

  sp_sync_ram #(.RDW(sp_ram_pkg::RDW_OLD)) u_sp_sync_ram_old (
    .inClk(inClk), .outClk(outClk), .outClr(outClr), .clkEn(clkEn),
    .addrStall(addrStall), .wrEn(wrEn), .rdEn(rdEn), .byteEn(byteEn),
    .addr(addr), .wrData(wrData), .rdQ(qOld));

  sp_sync_ram #(.OUT_REG(1'b0), .FLOW_THRU(1'b1)) u_sp_sync_ram_ft (
    .inClk(inClk), .outClk(outClk), .outClr(outClr), .clkEn(clkEn),
    .addrStall(addrStall), .wrEn(wrEn), .rdEn(rdEn), .byteEn(byteEn),
    .addr(addr), .wrData(wrData), .rdQ(qFt));

  typedef struct packed {
    bit        we;
    bit        re;
    bit        stall;
    bit [3:0]  be;
    bit [5:0]  a;
    bit [31:0] d;
    bit [31:0] eNew;
    bit [31:0] eOld;
    bit [31:0] eFt;
    bit        chkOld;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    // we re st be    a      data          new           old           flow
    '{1'b1,1'b0,1'b0,4'hF,6'd1,32'h11223344,32'h11223344,32'h00000000,32'h11223344,1'b0}, // R1 R4
    '{1'b1,1'b0,1'b0,4'hF,6'd2,32'hAABBCCDD,32'hAABBCCDD,32'h00000000,32'hAABBCCDD,1'b0}, // R1
    '{1'b0,1'b1,1'b0,4'h0,6'd1,32'h0,       32'h11223344,32'h11223344,32'h11223344,1'b1}, // R3
    '{1'b0,1'b1,1'b0,4'h0,6'd2,32'h0,       32'hAABBCCDD,32'hAABBCCDD,32'hAABBCCDD,1'b1}, // R3
    '{1'b1,1'b0,1'b0,4'h5,6'd1,32'hFFEEDDCC,32'h11EE33CC,32'h11223344,32'h11EE33CC,1'b1}, // R2 R5
    '{1'b0,1'b1,1'b0,4'h0,6'd1,32'h0,       32'h11EE33CC,32'h11EE33CC,32'h11EE33CC,1'b1}, // R2
    '{1'b0,1'b0,1'b0,4'h0,6'd2,32'h0,       32'h11EE33CC,32'h11EE33CC,32'hAABBCCDD,1'b1}, // R8 R10
    '{1'b0,1'b1,1'b0,4'h0,6'd2,32'h0,       32'hAABBCCDD,32'hAABBCCDD,32'hAABBCCDD,1'b1}, // R3
    '{1'b0,1'b1,1'b1,4'h0,6'd1,32'h0,       32'hAABBCCDD,32'hAABBCCDD,32'hAABBCCDD,1'b1}, // R6
    '{1'b1,1'b0,1'b1,4'hF,6'd1,32'h55555555,32'h55555555,32'hAABBCCDD,32'h55555555,1'b1}, // R6 R5
    '{1'b0,1'b1,1'b0,4'h0,6'd1,32'h0,       32'h11EE33CC,32'h11EE33CC,32'h11EE33CC,1'b1}, // R6
    '{1'b0,1'b1,1'b0,4'h0,6'd2,32'h0,       32'h55555555,32'h55555555,32'h55555555,1'b1}, // R6
    '{1'b1,1'b1,1'b0,4'h0,6'd1,32'h00000000,32'h11EE33CC,32'h11EE33CC,32'h11EE33CC,1'b1}, // R11 R2
    '{1'b0,1'b1,1'b0,4'h0,6'd1,32'h0,       32'h11EE33CC,32'h11EE33CC,32'h11EE33CC,1'b1}  // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on the falling edge, sample after the following outClk edge
  task automatic step(input bit ce, input bit we, input bit re, input bit st,
                      input bit [3:0] be, input bit [5:0] a, input bit [31:0] d);
    @(negedge inClk);
    clkEn = ce; wrEn = we; rdEn = re; addrStall = st;
    byteEn = be; addr = a; wrData = d;
    @(posedge inClk);
    #2;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge inClk);
    #2;
    check("R9 reset state", qNew, 32'h0);
    check("R9 reset state old", qOld, 32'h0);
    @(negedge inClk);
    outClr = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, VECS[i].we, VECS[i].re, VECS[i].stall, VECS[i].be, VECS[i].a, VECS[i].d);
      check($sformatf("R1-vector %0d R4 new-data port", i), qNew, VECS[i].eNew);
      if (VECS[i].chkOld) check($sformatf("R5 old-data vector %0d", i), qOld, VECS[i].eOld);
      check($sformatf("R10 flow-through vector %0d", i), qFt, VECS[i].eFt);
    end

    // R7: write presented with clkEn low is dropped
    step(1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 6'd1, 32'hDEADBEEF);
    check("R7 hold with clkEn low", qNew, 32'h11EE33CC);
    step(1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 6'd2, 32'h0);
    check("R3 read after disabled cycle", qNew, 32'h55555555);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'd1, 32'h0);
    check("R7 read ignored with clkEn low", qNew, 32'h55555555);
    check("R7 flow-through address held", qFt, 32'h55555555);
    step(1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 6'd1, 32'h0);
    check("R7 no write while disabled", qNew, 32'h11EE33CC);

    // R9: asynchronous clear between clock edges, memory intact
    @(negedge inClk);
    clkEn = 1'b1; wrEn = 1'b0; rdEn = 1'b0;
    outClr = 1'b1;
    #1;
    check("R9 clear without clock", qNew, 32'h0);
    #0.5;
    outClr = 1'b0;
    step(1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 6'd2, 32'h0);
    check("R9 memory kept after clear", qNew, 32'h55555555);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule